// File: doc/BRIEF.md
# Processor Interrupt Interface with Acknowledge and End-of-Interrupt

This block sits between an interrupt distributor and one processor. The distributor presents its best pending candidate (an ID, the number of the processor that raised it for software interrupts, and an 8-bit priority where a smaller number is more urgent). The block decides whether that candidate may interrupt the processor now, drives a single interrupt request line, and gives software a small 32-bit register window for enabling, masking, acknowledging and ending interrupts.

Software acknowledges an interrupt by reading a register. That read returns the packed identity of the candidate and records its priority on a small stack of active priorities. A later candidate can preempt only when it is more urgent than both the priority mask and the priority on top of that stack. Writing the acknowledged value back to the end-of-interrupt register retires the most recent active interrupt and restores the previous running priority. One-cycle strobes tell the distributor which ID was acknowledged and which was retired, so that it can update its own pending and active state.

Top module: `irq_cpuif`

## Requirements
- R1: After reset the request output is low, the enable bit (offset 0x00) and priority mask (offset 0x04) read 0, the running priority (offset 0x14) reads 0xFF and an acknowledge read returns 1023.
- R2: Bit 0 of the control register at offset 0x00 gates signalling. While it is 0 the request stays low and acknowledge reads return 1023.
- R3: A candidate is eligible only if its priority is strictly less than the 8-bit mask at offset 0x04. An equal value is blocked.
- R4: A read of offset 0x0C while a candidate is eligible returns the ID in bits 9:0, the source processor in bits 12:10 and zero above. In the next cycle, for that cycle only, it raises the acknowledge strobe with that ID.
- R5: An acknowledge read with nothing eligible returns 1023 (0x3FF), raises no strobe and leaves the running priority unchanged.
- R6: A successful acknowledge pushes the candidate priority. Offset 0x14 reads the top of the stack, or 0xFF when the stack is empty.
- R7: While an interrupt is active, a new candidate is eligible only if its priority is strictly less than the running priority.
- R8: A write to offset 0x10 whose bits 12:0 equal the most recently acknowledged value pops the stack. In the next cycle, for that cycle only, it raises the end-of-interrupt strobe with that ID.
- R9: An end-of-interrupt write whose bits 12:0 differ from the most recently acknowledged value, or that arrives with the stack empty, raises no strobe and leaves the running priority unchanged.
- R10: Offset 0x18 reads the candidate's packed source and ID while a candidate is presented, and 1023 otherwise.
- R11: Offset 0x08 stores the low 3 bits of a write and reads them back.
- R12: With DEPTH interrupts active, nothing is eligible and acknowledge reads return 1023.
- R13: The request output follows eligibility one clock after the state or candidate changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | 8 | Register byte offset |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the cycle of the read |
| candValid | input | 1 | Distributor presents a candidate |
| candId | input | 10 | Candidate interrupt ID |
| candSrc | input | 3 | Requesting processor of a software interrupt |
| candPrio | input | 8 | Candidate priority, lower is more urgent |
| ackStrobe | output | 1 | One-cycle acknowledge pulse to the distributor |
| ackId | output | 10 | ID being acknowledged |
| eoiStrobe | output | 1 | One-cycle end-of-interrupt pulse to the distributor |
| eoiId | output | 10 | ID being retired |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
Read data is combinational, so the bench samples it in the same cycle as the read, after the inputs settle and before the committing edge. The acknowledge and end-of-interrupt strobes are registered and appear in the cycle after the access, so the bench checks them at the falling edge that follows the access. The request output adds one register after any change to the control state or the candidate, so the bench waits two falling edges before it samples the output. Every expected value comes from the priority rules: strictly below both the mask and the running priority, with a bounded stack.

// File: rtl/irq_cpuif_pkg.sv
package irq_cpuif_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_MASK  = 8'h04;
  localparam logic [7:0] OFS_BPT   = 8'h08;
  localparam logic [7:0] OFS_ACK   = 8'h0C;
  localparam logic [7:0] OFS_EOI   = 8'h10;
  localparam logic [7:0] OFS_RUN   = 8'h14;
  localparam logic [7:0] OFS_HIGH  = 8'h18;

  typedef struct packed {
    logic ctrlWr;
    logic maskWr;
    logic bptWr;
    logic ackPush;
    logic eoiPop;
  } strobeT;
endpackage

// File: rtl/irq_cpuif_ctrl.sv
module irq_cpuif_ctrl
  import irq_cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int SRC_W  = 3,
  parameter int PRIO_W = 8,
  localparam int TAG_W = ID_W + SRC_W
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWrData,
  input  logic              candValid,
  input  logic [PRIO_W-1:0] candPrio,
  input  logic              enable,
  input  logic [PRIO_W-1:0] maskVal,
  input  logic [PRIO_W-1:0] runPrio,
  input  logic              stackFull,
  input  logic              stackEmpty,
  input  logic [TAG_W-1:0]  topTag,
  output logic              eligible,
  output strobeT            strb
);
  logic eoiMatch;

  // Preemption needs the candidate strictly below both the mask and the running priority
  assign eligible = enable && candValid && !stackFull &&
                    (candPrio < maskVal) && (candPrio < runPrio);

  assign eoiMatch = !stackEmpty && (busWrData[TAG_W-1:0] == topTag);

  always_comb begin
    strb         = '0;
    strb.ctrlWr  = busWrEn && (busAddr == OFS_CTRL);
    strb.maskWr  = busWrEn && (busAddr == OFS_MASK);
    strb.bptWr   = busWrEn && (busAddr == OFS_BPT);
    strb.ackPush = busRdEn && (busAddr == OFS_ACK) && eligible;
    strb.eoiPop  = busWrEn && (busAddr == OFS_EOI) && eoiMatch;
  end
endmodule

// File: rtl/irq_cpuif_dp.sv
module irq_cpuif_dp
  import irq_cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int SRC_W  = 3,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4,
  parameter int BPT_W  = 3,
  localparam int TAG_W = ID_W + SRC_W,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic              eligible,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWrData,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [SRC_W-1:0]  candSrc,
  input  logic [PRIO_W-1:0] candPrio,
  output logic [31:0]       busRdData,
  output logic              enable,
  output logic [PRIO_W-1:0] maskVal,
  output logic [PRIO_W-1:0] runPrio,
  output logic              stackFull,
  output logic              stackEmpty,
  output logic [TAG_W-1:0]  topTag,
  output logic              ackStrobe,
  output logic [ID_W-1:0]   ackId,
  output logic              eoiStrobe,
  output logic [ID_W-1:0]   eoiId,
  output logic              irqOut
);
  localparam logic [TAG_W-1:0] SPURIOUS = TAG_W'({ID_W{1'b1}});

  logic [BPT_W-1:0]  bptVal;
  logic [CNT_W-1:0]  depthQ;
  logic [PRIO_W-1:0] prioStk [DEPTH];
  logic [TAG_W-1:0]  tagStk  [DEPTH];
  logic [IDX_W-1:0]  topIdx, pushIdx;
  logic [TAG_W-1:0]  candTag;

  assign candTag    = {candSrc, candId};
  assign stackEmpty = (depthQ == '0);
  assign stackFull  = (depthQ == CNT_W'(DEPTH));
  assign topIdx     = IDX_W'(depthQ - 1'b1);
  assign pushIdx    = IDX_W'(depthQ);
  assign runPrio    = stackEmpty ? {PRIO_W{1'b1}} : prioStk[topIdx];
  assign topTag     = stackEmpty ? SPURIOUS : tagStk[topIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      maskVal <= '0;
      bptVal  <= '0;
    end else begin
      if (strb.ctrlWr) enable  <= busWrData[0];
      if (strb.maskWr) maskVal <= busWrData[PRIO_W-1:0];
      if (strb.bptWr)  bptVal  <= busWrData[BPT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) depthQ <= '0;
    else if (strb.ackPush) depthQ <= depthQ + 1'b1;
    else if (strb.eoiPop)  depthQ <= depthQ - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.ackPush) begin
      prioStk[pushIdx] <= candPrio;
      tagStk[pushIdx]  <= candTag;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackStrobe <= 1'b0;
      ackId     <= '0;
      eoiStrobe <= 1'b0;
      eoiId     <= '0;
      irqOut    <= 1'b0;
    end else begin
      ackStrobe <= strb.ackPush;
      eoiStrobe <= strb.eoiPop;
      irqOut    <= eligible;
      if (strb.ackPush) ackId <= candId;
      if (strb.eoiPop)  eoiId <= topTag[ID_W-1:0];
    end
  end

  always_comb begin
    case (busAddr)
      OFS_CTRL: busRdData = {31'b0, enable};
      OFS_MASK: busRdData = 32'(maskVal);
      OFS_BPT:  busRdData = 32'(bptVal);
      OFS_ACK:  busRdData = 32'(eligible ? candTag : SPURIOUS);
      OFS_RUN:  busRdData = 32'(runPrio);
      OFS_HIGH: busRdData = 32'(candValid ? candTag : SPURIOUS);
      default:  busRdData = '0;
    endcase
  end

  // R12: the active stack never holds more than DEPTH entries
  assert_depth_bound_R12: assert property (@(posedge clk) disable iff (!rstN)
    depthQ <= CNT_W'(DEPTH));

  // R7: every acknowledge makes the running priority strictly more urgent
  assert_push_raises_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackPush |=> (runPrio < $past(runPrio)));

  // R8: a retire pulse only follows a non-empty stack
  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (!rstN)
    eoiStrobe |-> ($past(depthQ) != '0));

  // R3: an acknowledged candidate was below the mask
  assert_ack_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |-> ($past(candPrio) < $past(maskVal)));

  // R2: the request only rises while signalling is enabled
  assert_irq_enabled_R2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(enable));
endmodule

// File: rtl/irq_cpuif.sv
module irq_cpuif
  import irq_cpuif_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int SRC_W  = 3,
  parameter int PRIO_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              candValid,
  input  logic [ID_W-1:0]   candId,
  input  logic [SRC_W-1:0]  candSrc,
  input  logic [PRIO_W-1:0] candPrio,
  output logic              ackStrobe,
  output logic [ID_W-1:0]   ackId,
  output logic              eoiStrobe,
  output logic [ID_W-1:0]   eoiId,
  output logic              irqOut
);
  localparam int TAG_W = ID_W + SRC_W;

  strobeT            strb;
  logic              eligible, enable, stackFull, stackEmpty;
  logic [PRIO_W-1:0] maskVal, runPrio;
  logic [TAG_W-1:0]  topTag;

  irq_cpuif_ctrl #(.ID_W(ID_W), .SRC_W(SRC_W), .PRIO_W(PRIO_W)) u_ctrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .busWrData(busWrData),
    .candValid(candValid), .candPrio(candPrio), .enable(enable), .maskVal(maskVal),
    .runPrio(runPrio), .stackFull(stackFull), .stackEmpty(stackEmpty), .topTag(topTag),
    .eligible(eligible), .strb(strb)
  );

  irq_cpuif_dp #(.ID_W(ID_W), .SRC_W(SRC_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .eligible(eligible), .busAddr(busAddr),
    .busWrData(busWrData), .candValid(candValid), .candId(candId), .candSrc(candSrc),
    .candPrio(candPrio), .busRdData(busRdData), .enable(enable), .maskVal(maskVal),
    .runPrio(runPrio), .stackFull(stackFull), .stackEmpty(stackEmpty), .topTag(topTag),
    .ackStrobe(ackStrobe), .ackId(ackId), .eoiStrobe(eoiStrobe), .eoiId(eoiId),
    .irqOut(irqOut)
  );
endmodule

// File: tb/irq_cpuif_tb.sv
module irq_cpuif_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0, busRdData;
  logic        candValid = 1'b0;
  logic [9:0]  candId = '0;
  logic [2:0]  candSrc = '0;
  logic [7:0]  candPrio = '0;
  logic        ackStrobe, eoiStrobe, irqOut;
  logic [9:0]  ackId, eoiId;

  int nChecks = 0, nErrors = 0;
  logic finished = 1'b0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  irq_cpuif u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .candValid(candValid), .candId(candId),
    .candSrc(candSrc), .candPrio(candPrio), .ackStrobe(ackStrobe), .ackId(ackId),
    .eoiStrobe(eoiStrobe), .eoiId(eoiId), .irqOut(irqOut)
  );

  // {enable, mask, prio, id, src, expected request}
  localparam int NV = 8;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 8'hFF, 8'h40, 10'd45,   3'd2, 1'b0},
    {1'b1, 8'hFF, 8'h40, 10'd45,   3'd2, 1'b1},
    {1'b1, 8'h40, 8'h40, 10'd33,   3'd0, 1'b0},
    {1'b1, 8'h41, 8'h40, 10'd33,   3'd1, 1'b1},
    {1'b1, 8'h00, 8'h00, 10'd7,    3'd0, 1'b0},
    {1'b1, 8'h10, 8'h0F, 10'd1,    3'd5, 1'b1},
    {1'b1, 8'hFF, 8'hFE, 10'd1020, 3'd0, 1'b1},
    {1'b1, 8'h80, 8'h90, 10'd64,   3'd3, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic present(input logic [7:0] p, input logic [9:0] id, input logic [2:0] s);
    @(negedge clk);
    candValid = 1'b1; candPrio = p; candId = id; candSrc = s;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", {31'b0, irqOut}, 32'd0);
    busRead(8'h00, rd); check("R1 ctrl", rd, 32'd0);
    busRead(8'h04, rd); check("R1 mask", rd, 32'd0);
    busRead(8'h14, rd); check("R1 run", rd, 32'hFF);
    busRead(8'h0C, rd); check("R1 ack", rd, 32'd1023);

    // Table: R2 R3 R4 R6 R8 R13
    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      logic [31:0] tag;
      v = VEC[i];
      tag = {19'b0, v[3:1], v[13:4]};
      busWrite(8'h00, {31'b0, v[30]});
      busWrite(8'h04, {24'b0, v[29:22]});
      present(v[21:14], v[13:4], v[3:1]);
      settle();
      check("R13 R2 R3 irq", {31'b0, irqOut}, {31'b0, v[0]});
      busRead(8'h0C, rd);
      check("R4 R3 ack value", rd, v[0] ? tag : 32'd1023);
      check("R4 ack strobe", {31'b0, ackStrobe}, {31'b0, v[0]});
      if (v[0]) begin
        check("R4 ack id", {22'b0, ackId}, {22'b0, v[13:4]});
        busRead(8'h14, rd); check("R6 run", rd, {24'b0, v[21:14]});
        busWrite(8'h10, tag);
        check("R8 eoi strobe", {31'b0, eoiStrobe}, 32'd1);
        check("R8 eoi id", {22'b0, eoiId}, {22'b0, v[13:4]});
        busRead(8'h14, rd); check("R8 run restored", rd, 32'hFF);
      end
      @(negedge clk); candValid = 1'b0;
    end

    busWrite(8'h00, 32'd1);
    busWrite(8'h04, 32'hFF);

    // R5: nothing presented
    settle();
    busRead(8'h0C, rd); check("R5 spurious", rd, 32'd1023);
    check("R5 no strobe", {31'b0, ackStrobe}, 32'd0);
    busRead(8'h14, rd); check("R5 run unchanged", rd, 32'hFF);
    // R10 highest pending
    busRead(8'h18, rd); check("R10 none", rd, 32'd1023);
    present(8'h22, 10'd300, 3'd6);
    busRead(8'h18, rd); check("R10 cand", rd, {19'b0, 3'd6, 10'd300});
    // R11 binary point
    busWrite(8'h08, 32'hFF);
    busRead(8'h08, rd); check("R11 bpt", rd, 32'd7);

    // R7 nesting
    present(8'h50, 10'd10, 3'd0);
    busRead(8'h0C, rd); check("R7 first ack", rd, 32'd10);
    present(8'h60, 10'd11, 3'd0); settle();
    check("R7 lower urgency blocked", {31'b0, irqOut}, 32'd0);
    present(8'h50, 10'd12, 3'd0); settle();
    check("R7 equal blocked", {31'b0, irqOut}, 32'd0);
    busRead(8'h0C, rd); check("R7 equal ack spurious", rd, 32'd1023);
    present(8'h30, 10'd20, 3'd1); settle();
    check("R7 preempt irq", {31'b0, irqOut}, 32'd1);
    busRead(8'h0C, rd); check("R7 nested ack", rd, {19'b0, 3'd1, 10'd20});
    busRead(8'h14, rd); check("R6 nested run", rd, 32'h30);
    // R9 mismatched EOI
    busWrite(8'h10, 32'd10);
    check("R9 no strobe", {31'b0, eoiStrobe}, 32'd0);
    busRead(8'h14, rd); check("R9 run unchanged", rd, 32'h30);
    busWrite(8'h10, {19'b0, 3'd1, 10'd20});
    check("R8 nested eoi", {22'b0, eoiId}, 32'd20);
    busRead(8'h14, rd); check("R8 run back", rd, 32'h50);
    busWrite(8'h10, 32'd10);
    busRead(8'h14, rd); check("R8 run empty", rd, 32'hFF);
    busWrite(8'h10, 32'd10);
    check("R9 empty eoi ignored", {31'b0, eoiStrobe}, 32'd0);

    // R12 full stack
    for (int k = 0; k < 4; k++) begin
      present(8'(8'h80 - 8'h20 * k), 10'(100 + k), 3'd0);
      busRead(8'h0C, rd); check("R12 fill", rd, 32'(100 + k));
    end
    present(8'h10, 10'd200, 3'd0); settle();
    check("R12 full irq", {31'b0, irqOut}, 32'd0);
    busRead(8'h0C, rd); check("R12 full ack", rd, 32'd1023);
    busRead(8'h14, rd); check("R12 full run", rd, 32'h20);

    // R2 disable while candidate eligible
    busWrite(8'h10, 32'd103);
    busWrite(8'h00, 32'd0); settle();
    check("R2 disabled irq", {31'b0, irqOut}, 32'd0);
    busRead(8'h0C, rd); check("R2 disabled ack", rd, 32'd1023);

    finish();
  end
endmodule